// File: doc/BRIEF.md
# Virtual Interrupt List Bank

This block holds a small set of list entries that a hypervisor loads before it runs a virtual CPU. Each entry describes one virtual interrupt: its number, a two-bit life-cycle state, and an optional link to a physical interrupt source identified by its own number. The guest sees the bank through two ports. The acknowledge port hands out the first pending entry and marks it active. The deactivate port retires an active entry by virtual number.

When the guest deactivates an entry that is linked to a physical source, the block raises a single-cycle request that carries the physical number. That request is meant for the physical distributor, which can then end the active state of the real interrupt without hypervisor help. The hypervisor writes and clears entries through an indexed port. It reads them back through a combinational read port. Writes that would give a linked entry both pending and active state are refused and recorded in a sticky error flag.

Top module: `vlr_bank`

## Requirements
- R1: After reset every entry is in state inactive (code 0), the error flag is 0, and neither `ack_valid` nor `pdeact_valid` is asserted.
- R2: A hypervisor write to entry `hv_wr_idx` stores the virtual number, state, link bit and physical number. The values appear on the read port for that index from the next cycle. State codes are 0 inactive, 1 pending, 2 active, 3 pending+active.
- R3: A write with the link bit set and state code 3 is refused. The entry keeps its old contents and `hv_err` becomes 1. `hv_err` stays 1 through later writes until `hv_err_clr` is pulsed; a refused write in the same cycle as the clear wins. No stored entry ever has the link bit set with state code 3.
- R4: A guest acknowledge selects the lowest-index entry in state pending (code 1) and moves it to active (code 2). In the cycle after the request, `ack_valid` is high for one cycle with that entry's virtual number on `ack_vnum`.
- R5: An acknowledge while no entry is in state code 1 returns 1023 (all ones at the virtual number width) and changes no entry. An entry in code 3 is not eligible.
- R6: A guest deactivate with number V acts on the lowest-index entry whose virtual number is V and whose state is 2 or 3. Code 2 becomes 0 and code 3 becomes 1. With no such entry nothing changes.
- R7: A deactivate that hits a linked entry drives `pdeact_valid` high in that same cycle, with the entry's physical number on `pdeact_pnum`, for exactly that one cycle.
- R8: A deactivate that hits an unlinked entry, or hits no entry, produces no `pdeact_valid`.
- R9: A hypervisor clear puts the entry at `hv_clr_idx` into state 0 in the next cycle and never produces `pdeact_valid`.
- R10: An acknowledge or deactivate in a cycle where the hypervisor also writes or clears any entry is ignored: no `ack_valid`, no `pdeact_valid`, no state change.
- R11: An acknowledge and a deactivate in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_wr_en | input | 1 | Hypervisor write strobe |
| hv_wr_idx | input | 2 | Entry written |
| hv_wr_vnum | input | 10 | Virtual number to store |
| hv_wr_state | input | 2 | State code to store |
| hv_wr_link | input | 1 | Link-to-physical bit to store |
| hv_wr_pnum | input | 10 | Physical number to store |
| hv_clr_en | input | 1 | Hypervisor clear strobe |
| hv_clr_idx | input | 2 | Entry cleared |
| hv_err_clr | input | 1 | Clears the sticky error flag |
| hv_rd_idx | input | 2 | Entry shown on the read port |
| hv_rd_vnum | output | 10 | Read virtual number |
| hv_rd_state | output | 2 | Read state code |
| hv_rd_link | output | 1 | Read link bit |
| hv_rd_pnum | output | 10 | Read physical number |
| hv_err | output | 1 | Sticky refused-write flag |
| g_ack | input | 1 | Guest acknowledge request |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vnum | output | 10 | Acknowledged virtual number or 1023 |
| g_deact | input | 1 | Guest deactivate request |
| g_deact_vnum | input | 10 | Virtual number to deactivate |
| pdeact_valid | output | 1 | Physical deactivate request |
| pdeact_pnum | output | 10 | Physical number to deactivate |

## Verification
The bench targets the selection corners. It acknowledges with both a pending and a pending+active entry present. A design that picked the wrong index, or treated pending+active as pending, would return the wrong number instead of 33, 40 or the spurious 1023. It deactivates linked, unlinked, pending+active and unmatched numbers, and it clears a linked active entry. A design that emitted the physical request on the wrong path would leave an unexpected pulse in the scoreboard. A missing or wrong physical number would show as a miscompare. The bench also collides guest requests with hypervisor traffic and checks the refused-write error both as sticky and as cleared. A design that let the guest win the collision, or that stored the illegal combination, would change the state read back.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_BOTH = 2'd3
  } vst_e;
endpackage

// File: rtl/vlr_pick.sv
module vlr_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/vlr_slot.sv
module vlr_slot
  import vlr_pkg::*;
#(
  parameter int VW = 10,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          clr,
  input  logic          ack_hit,
  input  logic          dea_hit,
  input  logic [VW-1:0] ld_vnum,
  input  vst_e          ld_st,
  input  logic          ld_link,
  input  logic [PW-1:0] ld_pnum,
  output logic [VW-1:0] vnum_q,
  output vst_e          st_q,
  output logic          link_q,
  output logic [PW-1:0] pnum_q
);
  logic [VW-1:0] vnum_d;
  vst_e          st_d;
  logic          link_d;
  logic [PW-1:0] pnum_d;
  logic          en;

  assign en = ld | clr | ack_hit | dea_hit;

  always_comb begin
    vnum_d = vnum_q;
    st_d   = st_q;
    link_d = link_q;
    pnum_d = pnum_q;
    if (clr) begin
      st_d   = ST_IDLE;
      link_d = 1'b0;
    end else if (ld) begin
      vnum_d = ld_vnum;
      st_d   = ld_st;
      link_d = ld_link;
      pnum_d = ld_pnum;
    end else if (ack_hit) begin
      st_d = ST_ACT;
    end else if (dea_hit) begin
      st_d = (st_q == ST_BOTH) ? ST_PEND : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vnum_q <= '0;
      st_q   <= ST_IDLE;
      link_q <= 1'b0;
      pnum_q <= '0;
    end else if (en) begin
      vnum_q <= vnum_d;
      st_q   <= st_d;
      link_q <= link_d;
      pnum_q <= pnum_d;
    end
  end

  AST_NO_LINKED_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_q && st_q == ST_BOTH)); // R3
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> st_q == ST_IDLE); // R9
  AST_ACK_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !clr && !ld) |=> st_q == ST_ACT); // R4
  AST_ACK_DEA_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_hit && dea_hit)); // R11
endmodule

// File: rtl/vlr_bank.sv
module vlr_bank
  import vlr_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int VW      = 10,
  parameter int PW      = 10,
  localparam int IW     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_wr_en,
  input  logic [IW-1:0] hv_wr_idx,
  input  logic [VW-1:0] hv_wr_vnum,
  input  logic [1:0]    hv_wr_state,
  input  logic          hv_wr_link,
  input  logic [PW-1:0] hv_wr_pnum,
  input  logic          hv_clr_en,
  input  logic [IW-1:0] hv_clr_idx,
  input  logic          hv_err_clr,
  input  logic [IW-1:0] hv_rd_idx,
  output logic [VW-1:0] hv_rd_vnum,
  output logic [1:0]    hv_rd_state,
  output logic          hv_rd_link,
  output logic [PW-1:0] hv_rd_pnum,
  output logic          hv_err,
  input  logic          g_ack,
  output logic          ack_valid,
  output logic [VW-1:0] ack_vnum,
  input  logic          g_deact,
  input  logic [VW-1:0] g_deact_vnum,
  output logic          pdeact_valid,
  output logic [PW-1:0] pdeact_pnum
);
  localparam logic [VW-1:0] SPUR = '1;

  logic [VW-1:0] vnum_a [NUM_ENT];
  vst_e          st_a   [NUM_ENT];
  logic [PW-1:0] pnum_a [NUM_ENT];
  logic [NUM_ENT-1:0] link_v, pend_v, dea_c, ack_g, dea_g;
  logic [NUM_ENT-1:0] ld_v, clr_v, ack_hit, dea_hit;
  logic ack_any, dea_any, hv_busy, wr_bad, wr_ok, ack_go, dea_go;
  logic [VW-1:0] ack_sel;
  logic [PW-1:0] dea_pnum;
  logic          dea_link;
  logic          ack_vld_d, ack_vld_q, err_d, err_q;
  logic [VW-1:0] ack_id_d, ack_id_q;

  assign hv_busy = hv_wr_en | hv_clr_en;
  assign wr_bad  = hv_wr_en & hv_wr_link & (vst_e'(hv_wr_state) == ST_BOTH);
  assign wr_ok   = hv_wr_en & ~wr_bad;
  assign ack_go  = g_ack & ~hv_busy;
  assign dea_go  = g_deact & ~hv_busy;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    assign ld_v[i]    = wr_ok & (hv_wr_idx == IW'(i));
    assign clr_v[i]   = hv_clr_en & (hv_clr_idx == IW'(i));
    assign pend_v[i]  = (st_a[i] == ST_PEND);
    assign dea_c[i]   = ((st_a[i] == ST_ACT) || (st_a[i] == ST_BOTH)) &&
                        (vnum_a[i] == g_deact_vnum);
    assign ack_hit[i] = ack_go & ack_g[i];
    assign dea_hit[i] = dea_go & dea_g[i];

    vlr_slot #(.VW(VW), .PW(PW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld_v[i]),
      .clr     (clr_v[i]),
      .ack_hit (ack_hit[i]),
      .dea_hit (dea_hit[i]),
      .ld_vnum (hv_wr_vnum),
      .ld_st   (vst_e'(hv_wr_state)),
      .ld_link (hv_wr_link),
      .ld_pnum (hv_wr_pnum),
      .vnum_q  (vnum_a[i]),
      .st_q    (st_a[i]),
      .link_q  (link_v[i]),
      .pnum_q  (pnum_a[i])
    );
  end

  vlr_pick #(.N(NUM_ENT)) u_pick_ack (
    .req (pend_v),
    .gnt (ack_g),
    .any (ack_any)
  );

  vlr_pick #(.N(NUM_ENT)) u_pick_dea (
    .req (dea_c),
    .gnt (dea_g),
    .any (dea_any)
  );

  always_comb begin
    ack_sel  = '0;
    dea_pnum = '0;
    dea_link = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ack_g[i]) ack_sel = ack_sel | vnum_a[i];
      if (dea_g[i]) begin
        dea_pnum = dea_pnum | pnum_a[i];
        dea_link = dea_link | link_v[i];
      end
    end
  end

  assign pdeact_valid = dea_go & dea_any & dea_link;
  assign pdeact_pnum  = dea_pnum;

  always_comb begin
    ack_vld_d = ack_go;
    ack_id_d  = ack_any ? ack_sel : SPUR;
    err_d     = err_q;
    if (hv_err_clr) err_d = 1'b0;
    if (wr_bad)     err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld_q <= 1'b0;
      ack_id_q  <= '0;
      err_q     <= 1'b0;
    end else begin
      ack_vld_q <= ack_vld_d;
      err_q     <= err_d;
      if (ack_go) ack_id_q <= ack_id_d;
    end
  end

  assign ack_valid   = ack_vld_q;
  assign ack_vnum    = ack_id_q;
  assign hv_err      = err_q;
  assign hv_rd_vnum  = vnum_a[hv_rd_idx];
  assign hv_rd_state = st_a[hv_rd_idx];
  assign hv_rd_link  = link_v[hv_rd_idx];
  assign hv_rd_pnum  = pnum_a[hv_rd_idx];

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(g_ack)); // R4
  AST_PDEACT_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    pdeact_valid |-> (g_deact && !hv_wr_en && !hv_clr_en)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_err && !hv_err_clr) |=> hv_err); // R3
  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_wr_en && hv_wr_link && hv_wr_state == 2'd3) |=> hv_err); // R3
endmodule

// File: tb/vlr_bank_tb.sv
module vlr_bank_tb;
  logic       clk, rst_n;
  logic       hv_wr_en, hv_wr_link, hv_clr_en, hv_err_clr, g_ack, g_deact;
  logic [1:0] hv_wr_idx, hv_clr_idx, hv_rd_idx, hv_wr_state;
  logic [9:0] hv_wr_vnum, hv_wr_pnum, g_deact_vnum;
  logic [9:0] hv_rd_vnum, hv_rd_pnum, ack_vnum, pdeact_pnum;
  logic [1:0] hv_rd_state;
  logic       hv_rd_link, hv_err, ack_valid, pdeact_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int    ack_q[$], pd_q[$];
  string ack_t[$], pd_t[$];

  vlr_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .hv_wr_en(hv_wr_en), .hv_wr_idx(hv_wr_idx), .hv_wr_vnum(hv_wr_vnum),
    .hv_wr_state(hv_wr_state), .hv_wr_link(hv_wr_link), .hv_wr_pnum(hv_wr_pnum),
    .hv_clr_en(hv_clr_en), .hv_clr_idx(hv_clr_idx), .hv_err_clr(hv_err_clr),
    .hv_rd_idx(hv_rd_idx), .hv_rd_vnum(hv_rd_vnum), .hv_rd_state(hv_rd_state),
    .hv_rd_link(hv_rd_link), .hv_rd_pnum(hv_rd_pnum), .hv_err(hv_err),
    .g_ack(g_ack), .ack_valid(ack_valid), .ack_vnum(ack_vnum),
    .g_deact(g_deact), .g_deact_vnum(g_deact_vnum),
    .pdeact_valid(pdeact_valid), .pdeact_pnum(pdeact_pnum)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ack_valid) begin
        if (ack_q.size() == 0) chk(0, "R10 unexpected ack", int'(ack_vnum), -1);
        else begin
          int e; string t;
          e = ack_q.pop_front(); t = ack_t.pop_front();
          chk(int'(ack_vnum) == e, t, int'(ack_vnum), e);
        end
      end
      if (pdeact_valid) begin
        if (pd_q.size() == 0) chk(0, "R8/R9 unexpected pdeact", int'(pdeact_pnum), -1);
        else begin
          int e; string t;
          e = pd_q.pop_front(); t = pd_t.pop_front();
          chk(int'(pdeact_pnum) == e, t, int'(pdeact_pnum), e);
        end
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic idle();
    hv_wr_en = 0; hv_clr_en = 0; hv_err_clr = 0; g_ack = 0; g_deact = 0;
  endtask

  task automatic wr(input int i, v, s, l, p);
    step();
    hv_wr_en = 1; hv_wr_idx = 2'(i); hv_wr_vnum = 10'(v);
    hv_wr_state = 2'(s); hv_wr_link = l[0]; hv_wr_pnum = 10'(p);
    step(); idle();
  endtask

  task automatic clr(input int i);
    step(); hv_clr_en = 1; hv_clr_idx = 2'(i); step(); idle();
  endtask

  task automatic ack(input int e, input string t);
    step(); ack_q.push_back(e); ack_t.push_back(t); g_ack = 1; step(); idle();
  endtask

  task automatic dea(input int v, input bit pulse, input int p, input string t);
    step();
    if (pulse) begin pd_q.push_back(p); pd_t.push_back(t); end
    g_deact = 1; g_deact_vnum = 10'(v);
    step(); idle();
  endtask

  task automatic rd(input int i, v, s, l, p, input string t);
    step(); hv_rd_idx = 2'(i); #2;
    chk(int'(hv_rd_state) == s, {t, " state"}, int'(hv_rd_state), s);
    if (v >= 0) chk(int'(hv_rd_vnum) == v, {t, " vnum"}, int'(hv_rd_vnum), v);
    if (l >= 0) chk(int'(hv_rd_link) == l, {t, " link"}, int'(hv_rd_link), l);
    if (p >= 0) chk(int'(hv_rd_pnum) == p, {t, " pnum"}, int'(hv_rd_pnum), p);
  endtask

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    rst_n = 0; idle();
    hv_wr_idx = 0; hv_wr_vnum = 0; hv_wr_state = 0; hv_wr_link = 0; hv_wr_pnum = 0;
    hv_clr_idx = 0; hv_rd_idx = 0; g_deact_vnum = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 4; i++) rd(i, -1, 0, 0, -1, "R1");
    chk(hv_err == 0, "R1 err", int'(hv_err), 0);
    chk(ack_valid == 0 && pdeact_valid == 0, "R1 outputs", int'(ack_valid), 0);
    // R2 load
    wr(0, 33, 1, 0, 0);
    wr(1, 40, 1, 1, 500);
    wr(2, 50, 3, 0, 0);
    wr(3, 61, 2, 1, 777);
    rd(1, 40, 1, 1, 500, "R2");
    rd(3, 61, 2, 1, 777, "R2");
    // R3 refused write, sticky, clear
    wr(2, 90, 3, 1, 12);
    rd(2, 50, 3, 0, 0, "R3 unchanged");
    chk(hv_err == 1, "R3 err set", int'(hv_err), 1);
    wr(0, 33, 1, 0, 0);
    chk(hv_err == 1, "R3 err sticky", int'(hv_err), 1);
    step(); hv_err_clr = 1; step(); idle();
    chk(hv_err == 0, "R3 err clear", int'(hv_err), 0);
    // R4 acknowledge lowest pending
    ack(33, "R4 ack e0");
    rd(0, 33, 2, 0, -1, "R4 active");
    ack(40, "R4 ack e1");
    rd(1, 40, 2, 1, 500, "R4 active");
    // R5 spurious (pending+active not eligible)
    ack(1023, "R5 spurious");
    rd(2, 50, 3, 0, -1, "R5 untouched");
    // R7 linked deactivate
    dea(40, 1, 500, "R7 pdeact");
    rd(1, -1, 0, -1, -1, "R7 idle");
    // R8 unlinked deactivate
    dea(33, 0, 0, "R8");
    rd(0, -1, 0, -1, -1, "R8 idle");
    // R6 pending+active -> pending; unmatched ignored
    dea(50, 0, 0, "R6");
    rd(2, 50, 1, -1, -1, "R6 to pending");
    dea(99, 0, 0, "R6");
    rd(3, 61, 2, 1, 777, "R6 no match");
    // R11 simultaneous ack and deactivate
    step();
    ack_q.push_back(50); ack_t.push_back("R11 ack");
    pd_q.push_back(777); pd_t.push_back("R11 pdeact");
    g_ack = 1; g_deact = 1; g_deact_vnum = 10'd61;
    step(); idle();
    rd(2, 50, 2, -1, -1, "R11 e2");
    rd(3, 61, 0, -1, -1, "R11 e3");
    // R9 clear never pulses
    wr(3, 61, 2, 1, 777);
    clr(3);
    rd(3, -1, 0, -1, -1, "R9 cleared");
    // R10 guest ops collide with hypervisor traffic
    wr(0, 70, 1, 0, 0);
    step(); g_ack = 1; hv_clr_en = 1; hv_clr_idx = 2'd3; step(); idle();
    rd(0, 70, 1, 0, -1, "R10 ack blocked");
    step(); g_deact = 1; g_deact_vnum = 10'd50;
    hv_wr_en = 1; hv_wr_idx = 2'd3; hv_wr_vnum = 10'd5; hv_wr_state = 2'd0;
    hv_wr_link = 0; hv_wr_pnum = 0;
    step(); idle();
    rd(2, 50, 2, -1, -1, "R10 deact blocked");
    ack(70, "R10 later ack");
    repeat (3) step();
    chk(ack_q.size() == 0, "R4 ack queue drained", ack_q.size(), 0);
    chk(pd_q.size() == 0, "R7 pdeact queue drained", pd_q.size(), 0);
    summary();
  end
endmodule